// File: doc/BRIEF.md
# Per-Block Backend Selector

This block decides, for each entry of a 16-entry block table, whether that code block runs on the dynamically scheduled backend or on the statically scheduled in-order backend. An entry is allocated in dynamic mode. While in dynamic mode, the dynamic backend reports a signature of each issue order it produced for the block. A run of identical signatures of the configured length moves the entry to static mode. In the same cycle the block raises a one-cycle request to capture that schedule.

While in static mode, the static backend reports how many stalls it took that a dynamic scheduler would have avoided. These counts accumulate. Once the running total passes a threshold, the entry returns to dynamic mode with its history wiped. The two report ports can fire in the same cycle. Each report is honoured only when the entry is valid and in the mode whose backend sent it, so a report that arrives after the entry has moved on does nothing. A single strobe invalidates the whole table.

Top module: `blk_mode_sel`

## Requirements
- R1: After reset every bit of `mode_static` is 0 and `rec_vld` is 0.
- R2: An allocate of entry i makes it valid in dynamic mode (`mode_static[i]`=0) with its stability count, stored signature and stall total cleared, from the next cycle.
- R3: A valid dynamic-mode entry that receives N_STABLE (default 4) consecutive dynamic reports with identical signatures shows `mode_static[i]`=1 in the cycle after the last of them, and not earlier.
- R4: A dynamic report whose signature differs from the stored one stores the new signature and restarts the run at 1, so N_STABLE identical reports counted from that one are needed.
- R5: `rec_vld` is high for exactly one cycle, with `rec_idx` equal to the entry, in the first cycle in which that entry's `mode_static` bit reads 1. It is low otherwise.
- R6: Static-backend stall counts accumulate per entry (saturating). The entry returns to dynamic mode in the cycle after the total first exceeds FS_THRESH (default 8). A total equal to FS_THRESH keeps it static.
- R7: On returning to dynamic mode, the stability count, stored signature and stall total are cleared, so N_STABLE fresh identical reports are needed again, even with the old signature.
- R8: Reports that address an invalid entry change nothing.
- R9: A dynamic report to a static-mode entry, and a static report to a dynamic-mode entry, are ignored. Stalls reported while dynamic do not count later.
- R10: `inv_all` makes every entry invalid and dynamic from the next cycle. Later reports are then ignored until the entry is allocated again.
- R11: Priority per entry: `inv_all` over allocate over reports. A report in the same cycle as an allocate of its entry is dropped.
- R12: Entries evolve independently. A report changes only the entry it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_vld | input | 1 | Allocate strobe |
| alloc_idx | input | 4 | Entry to allocate |
| inv_all | input | 1 | Invalidate every entry |
| dyn_vld | input | 1 | Dynamic-backend completion report valid |
| dyn_idx | input | 4 | Entry addressed by the dynamic report |
| dyn_sig | input | 16 | Issue-order signature of the dynamic run |
| sta_vld | input | 1 | Static-backend completion report valid |
| sta_idx | input | 4 | Entry addressed by the static report |
| sta_stalls | input | 4 | Avoidable stalls seen in the static run |
| mode_static | output | 16 | Per-entry mode: 1 static, 0 dynamic |
| rec_vld | output | 1 | One-cycle schedule capture request |
| rec_idx | output | 4 | Entry whose schedule is to be captured |

## Verification
Every result of this block appears exactly one cycle after the stimulus that causes it. A report, allocate or invalidate sampled at one rising edge shows on `mode_static` and on the `rec_vld`/`rec_idx` pair after that same edge. The driver changes inputs just after a rising edge. When it pushes an expectation, it stamps it as due on the following cycle. The monitor samples at falling edges and compares only the items whose due cycle has come. A mode flip that happens one report early or late, or a capture request that lasts two cycles, therefore misses its slot.

// File: rtl/blk_sel_pkg.sv
package blk_sel_pkg;

  typedef enum logic {
    MODE_DYN = 1'b0,
    MODE_STA = 1'b1
  } be_mode_e;

  // Saturating sum used by the stall accumulator.
  function automatic int unsigned sat_add(int unsigned a, int unsigned b, int unsigned lim);
    int unsigned s;
    s = a + b;
    return (s > lim) ? lim : s;
  endfunction

  // Length of the run of identical signatures after one more report.
  function automatic int unsigned next_run(int unsigned run, logic same);
    return same ? run + 1 : 1;
  endfunction

endpackage

// File: rtl/blk_sel_entry.sv
module blk_sel_entry
  import blk_sel_pkg::*;
#(
  parameter int SIG_W     = 16,
  parameter int STALL_W   = 4,
  parameter int N_STABLE  = 4,
  parameter int FS_THRESH = 8,
  parameter int RUN_W     = $clog2(N_STABLE + 1),
  parameter int FS_W      = $clog2(FS_THRESH + (1 << STALL_W) + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inv_i,
  input  logic               alloc_i,
  input  logic               dyn_hit_i,
  input  logic [SIG_W-1:0]   dyn_sig_i,
  input  logic               sta_hit_i,
  input  logic [STALL_W-1:0] sta_stalls_i,
  output logic               mode_o,
  output logic               flip_sta_o
);
  localparam int unsigned FS_MAX = (1 << FS_W) - 1;
  localparam logic [RUN_W-1:0] RUN_GOAL = RUN_W'(N_STABLE);
  localparam logic [FS_W-1:0]  FS_LIM   = FS_W'(FS_THRESH);

  logic               valid_q;
  be_mode_e           mode_q;
  logic [RUN_W-1:0]   run_q;
  logic [SIG_W-1:0]   sig_q;
  logic [FS_W-1:0]    fs_q;

  // Named internal events
  logic             dyn_upd, sta_upd, sig_same, flip_dyn;
  logic [RUN_W-1:0] run_nx;
  logic [FS_W-1:0]  fs_sum;

  always_comb begin
    dyn_upd  = valid_q && (mode_q == MODE_DYN) && dyn_hit_i && !alloc_i && !inv_i;
    sta_upd  = valid_q && (mode_q == MODE_STA) && sta_hit_i && !alloc_i && !inv_i;
    sig_same = (run_q != '0) && (sig_q == dyn_sig_i);
    run_nx   = RUN_W'(next_run(32'(run_q), sig_same));
    fs_sum   = FS_W'(sat_add(32'(fs_q), 32'(sta_stalls_i), FS_MAX));
    flip_sta_o = dyn_upd && (run_nx >= RUN_GOAL);
    flip_dyn   = sta_upd && (fs_sum > FS_LIM);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || inv_i) begin
      valid_q <= 1'b0;
      mode_q  <= MODE_DYN;
      run_q   <= '0;
      sig_q   <= '0;
      fs_q    <= '0;
    end else if (alloc_i) begin
      valid_q <= 1'b1;
      mode_q  <= MODE_DYN;
      run_q   <= '0;
      sig_q   <= '0;
      fs_q    <= '0;
    end else if (dyn_upd) begin
      sig_q <= dyn_sig_i;
      run_q <= run_nx;
      if (flip_sta_o) begin
        mode_q <= MODE_STA;
        fs_q   <= '0;
      end
    end else if (sta_upd) begin
      if (flip_dyn) begin
        mode_q <= MODE_DYN;
        run_q  <= '0;
        sig_q  <= '0;
        fs_q   <= '0;
      end else begin
        fs_q <= fs_sum;
      end
    end
  end

  assign mode_o = (mode_q == MODE_STA);

  // R2: allocation yields a clean dynamic entry
  p_alloc_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_i && !inv_i) |=> (valid_q && !mode_o && run_q == '0 && fs_q == '0));

  // R3: entering static mode needs a dynamic report in the previous cycle
  p_rise_from_dyn_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_o) |-> $past(dyn_hit_i));

  // R6: leaving static mode needs a stall report, allocate or invalidate
  p_fall_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_o) |-> $past(sta_hit_i || alloc_i || inv_i));

  // R7: history is empty after returning to dynamic mode
  p_clear_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_o) |-> (run_q == '0 && fs_q == '0));

  // R8: an invalid entry stays invalid and dynamic without an allocate
  p_invalid_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_q && !alloc_i) |=> (!valid_q && !mode_o));

  // R9: stall totals exist only in static mode
  p_stall_static_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_q != '0) |-> mode_o);

  // R10: invalidate empties the entry
  p_inv_r10: assert property (@(posedge clk) disable iff (!rst_n)
    inv_i |=> (!valid_q && !mode_o));

endmodule

// File: rtl/blk_sel_rec.sv
module blk_sel_rec #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] flip_vec_i,
  output logic               rec_vld_o,
  output logic [IDX_W-1:0]   rec_idx_o
);
  logic [IDX_W-1:0] enc;
  logic             any_flip;

  always_comb begin
    enc = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (flip_vec_i[i]) enc = IDX_W'(i);
    end
    any_flip = |flip_vec_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_vld_o <= 1'b0;
      rec_idx_o <= '0;
    end else begin
      rec_vld_o <= any_flip;
      rec_idx_o <= enc;
    end
  end

  // R5: at most one entry may move to static mode per cycle
  p_one_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flip_vec_i));

  // R5: a flip is followed by a capture request
  p_flip_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    any_flip |=> rec_vld_o);

endmodule

// File: rtl/blk_mode_sel.sv
module blk_mode_sel #(
  parameter int ENTRIES   = 16,
  parameter int SIG_W     = 16,
  parameter int STALL_W   = 4,
  parameter int N_STABLE  = 4,
  parameter int FS_THRESH = 8,
  parameter int IDX_W     = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_vld,
  input  logic [IDX_W-1:0]   alloc_idx,
  input  logic               inv_all,
  input  logic               dyn_vld,
  input  logic [IDX_W-1:0]   dyn_idx,
  input  logic [SIG_W-1:0]   dyn_sig,
  input  logic               sta_vld,
  input  logic [IDX_W-1:0]   sta_idx,
  input  logic [STALL_W-1:0] sta_stalls,
  output logic [ENTRIES-1:0] mode_static,
  output logic               rec_vld,
  output logic [IDX_W-1:0]   rec_idx
);
  logic [ENTRIES-1:0] flip_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic alloc_hit, dyn_hit, sta_hit;
    assign alloc_hit = alloc_vld && (alloc_idx == IDX_W'(g));
    assign dyn_hit   = dyn_vld   && (dyn_idx   == IDX_W'(g));
    assign sta_hit   = sta_vld   && (sta_idx   == IDX_W'(g));

    blk_sel_entry #(
      .SIG_W    (SIG_W),
      .STALL_W  (STALL_W),
      .N_STABLE (N_STABLE),
      .FS_THRESH(FS_THRESH)
    ) u_ent (
      .clk         (clk),
      .rst_n       (rst_n),
      .inv_i       (inv_all),
      .alloc_i     (alloc_hit),
      .dyn_hit_i   (dyn_hit),
      .dyn_sig_i   (dyn_sig),
      .sta_hit_i   (sta_hit),
      .sta_stalls_i(sta_stalls),
      .mode_o      (mode_static[g]),
      .flip_sta_o  (flip_vec[g])
    );
  end

  blk_sel_rec #(
    .ENTRIES(ENTRIES),
    .IDX_W  (IDX_W)
  ) u_rec (
    .clk       (clk),
    .rst_n     (rst_n),
    .flip_vec_i(flip_vec),
    .rec_vld_o (rec_vld),
    .rec_idx_o (rec_idx)
  );

  // R5: a capture request names an entry that is now static
  p_rec_static_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rec_vld |-> mode_static[rec_idx]);

  // R1/R10: the mode vector can only become nonzero through a capture request
  p_rise_has_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(mode_static) > $countones($past(mode_static))) |-> rec_vld);

endmodule

// File: tb/sim_blk_mode_sel.sv
module sim_blk_mode_sel;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_vld = 1'b0, inv_all = 1'b0, dyn_vld = 1'b0, sta_vld = 1'b0;
  logic [3:0]  alloc_idx = '0, dyn_idx = '0, sta_idx = '0, sta_stalls = '0;
  logic [15:0] dyn_sig = '0;
  logic [15:0] mode_static;
  logic        rec_vld;
  logic [3:0]  rec_idx;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  typedef struct {
    int    due;
    int    kind;   // 0 mode bit, 1 capture request, 2 whole mode vector zero
    int    idx;
    int    val;
    string tag;
  } exp_t;
  exp_t sb[$];

  blk_mode_sel u0 (
    .clk(clk), .rst_n(rst_n),
    .alloc_vld(alloc_vld), .alloc_idx(alloc_idx), .inv_all(inv_all),
    .dyn_vld(dyn_vld), .dyn_idx(dyn_idx), .dyn_sig(dyn_sig),
    .sta_vld(sta_vld), .sta_idx(sta_idx), .sta_stalls(sta_stalls),
    .mode_static(mode_static), .rec_vld(rec_vld), .rec_idx(rec_idx)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  // Monitor: compare due items at falling edges
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      case (e.kind)
        0: chk(e.tag, int'(mode_static[e.idx]), e.val);
        1: begin
             chk(e.tag, int'(rec_vld), e.val);
             if (e.val != 0) chk(e.tag, int'(rec_idx), e.idx);
           end
        default: chk(e.tag, int'(mode_static), 0);
      endcase
    end
  end

  task automatic exp_mode(input int i, input int v, input string tag);
    sb.push_back('{cyc + 1, 0, i, v, tag});
  endtask
  task automatic exp_rec(input int v, input int i, input string tag);
    sb.push_back('{cyc + 1, 1, i, v, tag});
  endtask
  task automatic exp_zero(input string tag);
    sb.push_back('{cyc + 1, 2, 0, 0, tag});
  endtask

  // Driver: inputs change just after a rising edge, held for one cycle
  task automatic drv(input logic av, input logic [3:0] ai, input logic iv,
                     input logic dv, input logic [3:0] di, input logic [15:0] ds,
                     input logic sv, input logic [3:0] si, input logic [3:0] ss);
    @(posedge clk); #1;
    alloc_vld = av; alloc_idx = ai; inv_all = iv;
    dyn_vld = dv; dyn_idx = di; dyn_sig = ds;
    sta_vld = sv; sta_idx = si; sta_stalls = ss;
  endtask
  task automatic nop();          drv(0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic alloc(input logic [3:0] i); drv(1, i, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic dyn(input logic [3:0] i, input logic [15:0] s); drv(0, 0, 0, 1, i, s, 0, 0, 0); endtask
  task automatic sta(input logic [3:0] i, input logic [3:0] n); drv(0, 0, 0, 0, 0, 0, 1, i, n); endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mode after reset", int'(mode_static), 0);
    chk("R1 rec after reset", int'(rec_vld), 0);

    // R2 / R3 / R5 on entry 3
    alloc(3); exp_mode(3, 0, "R2 alloc dynamic");
    for (int k = 0; k < 3; k++) begin
      dyn(3, 16'hAAAA); exp_mode(3, 0, "R3 not yet static"); exp_rec(0, 0, "R5 no early request");
    end
    dyn(3, 16'hAAAA); exp_mode(3, 1, "R3 static after N"); exp_rec(1, 3, "R5 request with index");
    nop(); exp_rec(0, 0, "R5 one-cycle pulse"); exp_mode(3, 1, "R3 stays static");

    // R4 on entry 5: A A A B B B B
    alloc(5);
    for (int k = 0; k < 3; k++) dyn(5, 16'h1111);
    for (int k = 0; k < 3; k++) dyn(5, 16'h2222);
    exp_mode(5, 0, "R4 run restarted on new signature");
    dyn(5, 16'h2222); exp_mode(5, 1, "R4 static after N of new signature");
    exp_rec(1, 5, "R5 request for entry 5");

    // R9: stale reports
    dyn(3, 16'h1234); exp_mode(3, 1, "R9 dynamic report to static entry ignored");
    exp_rec(0, 0, "R9 no request from stale report");
    alloc(6);
    sta(6, 4'd15); exp_mode(6, 0, "R9 static report to dynamic entry ignored");
    for (int k = 0; k < 4; k++) dyn(6, 16'hC0DE);
    exp_mode(6, 1, "R9 entry 6 static");
    sta(6, 4'd8); exp_mode(6, 1, "R9 earlier stalls not counted");

    // R6 boundary on entry 3
    sta(3, 4'd5); exp_mode(3, 1, "R6 total 5 stays static");
    sta(3, 4'd3); exp_mode(3, 1, "R6 total equal to threshold stays static");
    sta(3, 4'd1); exp_mode(3, 0, "R6 total above threshold returns dynamic");
    exp_mode(5, 1, "R12 entry 5 untouched");

    // R7: old signature no longer counts
    for (int k = 0; k < 3; k++) dyn(3, 16'hAAAA);
    exp_mode(3, 0, "R7 history cleared on return");
    dyn(3, 16'hAAAA); exp_mode(3, 1, "R7 static again after N fresh");
    exp_rec(1, 3, "R5 second request for entry 3");

    // R8: never-allocated entry 9
    for (int k = 0; k < 4; k++) dyn(9, 16'h9999);
    exp_mode(9, 0, "R8 invalid entry ignores reports");
    exp_rec(0, 0, "R8 no request for invalid entry");

    // R11: allocate beats a same-cycle report
    alloc(6); exp_mode(6, 0, "R11 realloc returns dynamic");
    for (int k = 0; k < 3; k++) dyn(6, 16'h5A5A);
    drv(1, 6, 0, 1, 6, 16'h5A5A, 0, 0, 0);
    for (int k = 0; k < 3; k++) dyn(6, 16'h5A5A);
    exp_mode(6, 0, "R11 report in allocate cycle dropped");
    dyn(6, 16'h5A5A); exp_mode(6, 1, "R11 static after N after allocate");

    // R10 + R11: invalidate beats allocate
    drv(1, 7, 1, 0, 0, 0, 0, 0, 0); exp_zero("R10 invalidate clears all modes");
    for (int k = 0; k < 4; k++) dyn(7, 16'h7777);
    exp_mode(7, 0, "R11 invalidate beats allocate");
    for (int k = 0; k < 4; k++) dyn(3, 16'h3333);
    exp_zero("R10 reports ignored after invalidate");
    exp_rec(0, 0, "R10 no request after invalidate");

    repeat (3) nop();
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule